// File: doc/BRIEF.md
# Self-Hosted Debug Exception Router

This block decides, on every cycle, whether a self-hosted debug exception may be raised at all, and at which exception level it is to be taken. It takes the current level, the security state, the register width of each level, the hypervisor routing bits, the monitor debug configuration word, the debug status/control word, the debug mask flag and two lock flags. From these it produces a target level, an enable, a single-step-active flag and a flag that marks a same-level exception.

The OS lock and the OS double lock are held inside the block. A small write port updates them. The OS lock can be written in two forms. In the 32-bit form a key value must match. In the 64-bit form the lock takes bit 0 of the data. All decision outputs are combinational from the inputs and the two lock registers. The lock registers are also brought out so that software or a neighbouring block can observe them.

Top module: `dbg_route_top`

## Requirements
- R1: When level 2 is enabled (`el2_en_i`) and either `hyp_tge_i` or `hyp_tde_i` is set, `tgt_el_o` is 2.
- R2: Otherwise `tgt_el_o` is 3 when level 3 is present, `el_is64_i[3]` is 0 and `secure_i` is 1. In every other case `tgt_el_o` is 1.
- R3: While `os_lock_o` or `os_dlock_o` is 1, `dbg_en_o` is 0.
- R4: In 64-bit state (`state64_i`=1), `dbg_en_o` is 0 at level 3. It is also 0 when the state is secure below level 3 and bit 16 of `mon_cfg_i` is 1.
- R5: In 64-bit state, when the target level equals the current level, `dbg_en_o` is 1 only if bit 13 of `dbg_ctl_i` is 1 and `dmask_i` is 0. When the target level is above the current level, `dbg_en_o` is 1.
- R6: In 32-bit secure state, `dbg_en_o` is 0 when `mon_cfg_i[15:14]` equals 2 and 1 for the values 0, 1 and 3. At level 0 with `sec_user_dbg_i` set, `dbg_en_o` is 1 whatever the field holds.
- R7: In 32-bit non-secure state, `dbg_en_o` is 1 at every level except level 2. At level 0 with `el_is64_i[1]`=1, the 64-bit rules of R4 and R5 apply instead.
- R8: `ss_active_o` is 1 exactly when bit 0 of `dbg_ctl_i` is 1, `el_is64_i[tgt_el_o]` is 1 and `dbg_en_o` is 1.
- R9: A write with `wr_sel_i`=0 updates the OS lock on the next clock edge. With `wr_form64_i`=0 the lock becomes 1 only when `wr_data_i` equals 0xC5ACCE55, and 0 for any other value. With `wr_form64_i`=1 the lock takes `wr_data_i[0]`.
- R10: After reset `os_lock_o` is 1 and `os_dlock_o` is 0. A write with `wr_sel_i`=1 loads `wr_data_i[0]` into the double lock.
- R11: `same_el_o` is 1 exactly when `tgt_el_o` equals `cur_el_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_el_i | input | 2 | Current exception level |
| secure_i | input | 1 | Secure state |
| state64_i | input | 1 | Current execution state is 64-bit |
| el_is64_i | input | 4 | Bit n set: level n runs in 64-bit mode |
| el2_en_i | input | 1 | Level 2 enabled in the current security state |
| el3_present_i | input | 1 | Level 3 implemented |
| hyp_tge_i | input | 1 | Hypervisor general trap bit |
| hyp_tde_i | input | 1 | Hypervisor trap-debug bit |
| mon_cfg_i | input | 32 | Monitor debug configuration word |
| sec_user_dbg_i | input | 1 | Secure user debug permitted |
| dbg_ctl_i | input | 32 | Debug status/control word |
| dmask_i | input | 1 | Debug mask flag |
| wr_en_i | input | 1 | Lock register write strobe |
| wr_sel_i | input | 1 | 0: OS lock, 1: double lock |
| wr_form64_i | input | 1 | OS lock write in 64-bit form |
| wr_data_i | input | 32 | Write data |
| tgt_el_o | output | 2 | Debug target level |
| dbg_en_o | output | 1 | Debug exceptions enabled |
| ss_active_o | output | 1 | Single-step active |
| same_el_o | output | 1 | Exception taken at the current level |
| os_lock_o | output | 1 | OS lock state |
| os_dlock_o | output | 1 | OS double-lock state |

## Verification
Routing is exercised with the hypervisor bits on and off, and with level 3 in each width and security state. These patterns separate the level-2 priority from the secure level-3 case and from the default. The 64-bit enable is driven with the target at and above the current level, and with the control bit and mask in each combination. This shows the same-level gate acting only when the levels coincide. The 32-bit paths sweep all four values of the monitor field, the user-debug override and the non-secure level 2 case. Level 0 is also run with a 64-bit level 1, where the monitor disable bit gives a result that differs from the 32-bit rule. The lock port is driven with the key, a wrong value and both forms, and each lock is checked to block enable and single-step.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EL_W = 2;
  localparam int unsigned NUM_EL = 4;

  typedef enum logic [EL_W-1:0] {
    EL0 = 2'd0,
    EL1 = 2'd1,
    EL2 = 2'd2,
    EL3 = 2'd3
  } el_e;

  localparam logic [1:0] SPD_OFF = 2'd2;
  localparam logic [WORD_W-1:0] LOCK_KEY = 32'hC5AC_CE55;
endpackage

// File: rtl/dbg_lock_regs.sv
module dbg_lock_regs #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = '1,
  parameter bit HAS_DLOCK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic              wr_form64_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              lock_o,
  output logic              dlock_o
);
  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (wr_en_i && !wr_sel_i)
      lock_d = wr_form64_i ? wr_data_i[0] : (wr_data_i == KEY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b1;
    else         lock_q <= lock_d;
  end

  generate
    if (HAS_DLOCK) begin : g_dlock
      logic dlock_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  dlock_q <= 1'b0;
        else if (wr_en_i && wr_sel_i) dlock_q <= wr_data_i[0];
      end
      assign dlock_o = dlock_q;
    end else begin : g_no_dlock
      assign dlock_o = 1'b0;
    end
  endgenerate

  assign lock_o = lock_q;
endmodule

// File: rtl/dbg_target_sel.sv
module dbg_target_sel
  import dbg_route_pkg::*;
#(
  parameter int unsigned N_EL = 4
) (
  input  logic [N_EL-1:0] el_is64_i,
  input  logic            secure_i,
  input  logic            el2_en_i,
  input  logic            el3_present_i,
  input  logic            hyp_tge_i,
  input  logic            hyp_tde_i,
  output el_e             tgt_o
);
  always_comb begin
    if (el2_en_i && (hyp_tge_i || hyp_tde_i))
      tgt_o = EL2;
    else if (el3_present_i && !el_is64_i[N_EL-1] && secure_i)
      tgt_o = EL3;
    else
      tgt_o = EL1;
  end
endmodule

// File: rtl/dbg_enable_eval.sv
module dbg_enable_eval
  import dbg_route_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_EL = 4,
  parameter int unsigned SDD_BIT = 16,
  parameter int unsigned SPD_LSB = 14,
  parameter int unsigned KDE_BIT = 13,
  parameter int unsigned SS_BIT = 0
) (
  input  el_e               cur_i,
  input  el_e               tgt_i,
  input  logic              secure_i,
  input  logic              state64_i,
  input  logic [N_EL-1:0]   el_is64_i,
  input  logic [DATA_W-1:0] mon_cfg_i,
  input  logic              sec_user_dbg_i,
  input  logic [DATA_W-1:0] dbg_ctl_i,
  input  logic              dmask_i,
  input  logic              lock_i,
  input  logic              dlock_i,
  output logic              en_o,
  output logic              ss_o
);
  logic en64, en32;
  logic [1:0] spd;

  assign spd = mon_cfg_i[SPD_LSB +: 2];

  // 64-bit rule set
  always_comb begin
    if (cur_i == EL3)
      en64 = 1'b0;
    else if (secure_i && mon_cfg_i[SDD_BIT])
      en64 = 1'b0;
    else if (cur_i == tgt_i)
      en64 = dbg_ctl_i[KDE_BIT] && !dmask_i;
    else
      en64 = (tgt_i > cur_i);
  end

  // 32-bit rule set; level 0 under a 64-bit level 1 defers to the 64-bit rules
  always_comb begin
    if (cur_i == EL0 && el_is64_i[1])
      en32 = en64;
    else if (secure_i) begin
      if (cur_i == EL0 && sec_user_dbg_i) en32 = 1'b1;
      else                                en32 = (spd != SPD_OFF);
    end else
      en32 = (cur_i != EL2);
  end

  assign en_o = !(lock_i || dlock_i) && (state64_i ? en64 : en32);
  assign ss_o = dbg_ctl_i[SS_BIT] && el_is64_i[tgt_i] && en_o;
endmodule

// File: rtl/dbg_route_top.sv
module dbg_route_top
  import dbg_route_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned N_EL = NUM_EL,
  parameter int unsigned SDD_BIT = 16,
  parameter int unsigned SPD_LSB = 14,
  parameter int unsigned KDE_BIT = 13,
  parameter int unsigned SS_BIT = 0,
  parameter bit HAS_DLOCK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cur_el_i,
  input  logic              secure_i,
  input  logic              state64_i,
  input  logic [N_EL-1:0]   el_is64_i,
  input  logic              el2_en_i,
  input  logic              el3_present_i,
  input  logic              hyp_tge_i,
  input  logic              hyp_tde_i,
  input  logic [DATA_W-1:0] mon_cfg_i,
  input  logic              sec_user_dbg_i,
  input  logic [DATA_W-1:0] dbg_ctl_i,
  input  logic              dmask_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic              wr_form64_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [1:0]        tgt_el_o,
  output logic              dbg_en_o,
  output logic              ss_active_o,
  output logic              same_el_o,
  output logic              os_lock_o,
  output logic              os_dlock_o
);
  localparam logic [DATA_W-1:0] KEY = DATA_W'(LOCK_KEY);

  el_e cur, tgt;
  logic lock, dlock;

  assign cur = el_e'(cur_el_i);

  dbg_lock_regs #(.DATA_W(DATA_W), .KEY(KEY), .HAS_DLOCK(HAS_DLOCK)) u_locks (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_form64_i, .wr_data_i,
    .lock_o(lock), .dlock_o(dlock)
  );

  dbg_target_sel #(.N_EL(N_EL)) u_tgt (
    .el_is64_i, .secure_i, .el2_en_i, .el3_present_i, .hyp_tge_i, .hyp_tde_i,
    .tgt_o(tgt)
  );

  dbg_enable_eval #(
    .DATA_W(DATA_W), .N_EL(N_EL), .SDD_BIT(SDD_BIT), .SPD_LSB(SPD_LSB),
    .KDE_BIT(KDE_BIT), .SS_BIT(SS_BIT)
  ) u_en (
    .cur_i(cur), .tgt_i(tgt), .secure_i, .state64_i, .el_is64_i, .mon_cfg_i,
    .sec_user_dbg_i, .dbg_ctl_i, .dmask_i, .lock_i(lock), .dlock_i(dlock),
    .en_o(dbg_en_o), .ss_o(ss_active_o)
  );

  assign tgt_el_o   = tgt;
  assign same_el_o  = (tgt == cur);
  assign os_lock_o  = lock;
  assign os_dlock_o = dlock;
endmodule

// File: rtl/dbg_route_chk.sv
module dbg_route_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  cur_el_i,
  input logic        secure_i,
  input logic        state64_i,
  input logic        el2_en_i,
  input logic        hyp_tge_i,
  input logic        hyp_tde_i,
  input logic [31:0] dbg_ctl_i,
  input logic        dmask_i,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic        wr_form64_i,
  input logic [31:0] wr_data_i,
  input logic [1:0]  tgt_el_o,
  input logic        dbg_en_o,
  input logic        ss_active_o,
  input logic        os_lock_o,
  input logic        os_dlock_o
);
  assert_route_el2_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el2_en_i && (hyp_tge_i || hyp_tde_i)) |-> tgt_el_o == 2'd2);

  assert_lock_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_lock_o || os_dlock_o) |-> !dbg_en_o);

  assert_no_el3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state64_i && cur_el_i == 2'd3) |-> !dbg_en_o);

  assert_mask_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state64_i && tgt_el_o == cur_el_i && (dmask_i || !dbg_ctl_i[13])) |-> !dbg_en_o);

  assert_ss_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_active_o |-> (dbg_en_o && dbg_ctl_i[0]));

  assert_key_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !wr_form64_i) |=> os_lock_o == ($past(wr_data_i) == 32'hC5AC_CE55));

  assert_bit0_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && wr_form64_i) |=> os_lock_o == $past(wr_data_i[0]));

  assert_dlock_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> os_dlock_o == $past(wr_data_i[0]));

  assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i) |=> $stable(os_lock_o) && $stable(os_dlock_o));
endmodule

bind dbg_route_top dbg_route_chk u_chk (.*);

// File: tb/sim_dbg_route_top.sv
module sim_dbg_route_top;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] cur_el;
  logic secure, state64, el2_en, el3_present, tge, tde, sud, dmask;
  logic [3:0] el64;
  logic [31:0] mon, ctl, wdata;
  logic wen, wsel, wf64;
  logic [1:0] tgt;
  logic en, ss, same, lk, dlk;

  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_route_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cur_el_i(cur_el), .secure_i(secure),
    .state64_i(state64), .el_is64_i(el64), .el2_en_i(el2_en),
    .el3_present_i(el3_present), .hyp_tge_i(tge), .hyp_tde_i(tde),
    .mon_cfg_i(mon), .sec_user_dbg_i(sud), .dbg_ctl_i(ctl), .dmask_i(dmask),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_form64_i(wf64), .wr_data_i(wdata),
    .tgt_el_o(tgt), .dbg_en_o(en), .ss_active_o(ss), .same_el_o(same),
    .os_lock_o(lk), .os_dlock_o(dlk)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic defaults();
    cur_el = 2'd1; secure = 0; state64 = 1; el64 = 4'b1111; el2_en = 0;
    el3_present = 1; tge = 0; tde = 0; sud = 0; dmask = 0;
    mon = '0; ctl = 32'h0000_2000; wen = 0; wsel = 0; wf64 = 0; wdata = '0;
  endtask

  task automatic lock_wr(logic sel, logic f64, logic [31:0] d);
    @(negedge clk);
    wen = 1; wsel = sel; wf64 = f64; wdata = d;
    @(negedge clk);
    wen = 0; wdata = '0;
    settle();
  endtask

  task automatic t_reset();
    settle();
    chk("R10 lock after reset", lk, 1);
    chk("R10 dlock after reset", dlk, 0);
    chk("R3 en while locked", en, 0);
    chk("R3 ss while locked", ss, 0);
  endtask

  task automatic t_lock_writes();
    lock_wr(0, 0, 32'h1234_5678);
    chk("R9 wrong key clears", lk, 0);
    chk("R3 en after unlock", en, 1);
    lock_wr(0, 0, 32'hC5AC_CE55);
    chk("R9 key sets", lk, 1);
    lock_wr(0, 1, 32'hFFFF_FFFE);
    chk("R9 64-bit bit0=0", lk, 0);
    lock_wr(0, 1, 32'h0000_0001);
    chk("R9 64-bit bit0=1", lk, 1);
    lock_wr(0, 1, 32'h0);
    chk("R9 64-bit clear", lk, 0);
  endtask

  task automatic t_target();
    el2_en = 1; tge = 1; settle();
    chk("R1 tge", tgt, 2);
    tge = 0; tde = 1; settle();
    chk("R1 tde", tgt, 2);
    el2_en = 0; secure = 1; el64 = 4'b0111; settle();
    chk("R2 secure 32-bit el3", tgt, 3);
    chk("R1 needs el2 enabled", tgt != 2, 1);
    el64 = 4'b1111; settle();
    chk("R2 64-bit el3", tgt, 1);
    secure = 0; el64 = 4'b0111; settle();
    chk("R2 non-secure", tgt, 1);
    secure = 1; el3_present = 0; settle();
    chk("R2 no el3", tgt, 1);
    defaults();
  endtask

  task automatic t_en64();
    cur_el = 3; settle();
    chk("R4 el3", en, 0);
    cur_el = 1; settle();
    chk("R5 same el kde", en, 1);
    chk("R11 same", same, 1);
    dmask = 1; settle();
    chk("R5 masked", en, 0);
    dmask = 0; ctl = 0; settle();
    chk("R5 kde clear", en, 0);
    cur_el = 0; settle();
    chk("R5 higher target", en, 1);
    chk("R11 not same", same, 0);
    cur_el = 1; el2_en = 1; tde = 1; dmask = 1; settle();
    chk("R5 el2 above el1", en, 1);
    cur_el = 2; settle();
    chk("R11 el2 same", same, 1);
    chk("R5 el2 same masked", en, 0);
    defaults(); secure = 1; mon = 32'h0001_0000; settle();
    chk("R4 secure disable bit", en, 0);
    defaults();
  endtask

  task automatic t_en32();
    state64 = 0; secure = 1; cur_el = 1;
    for (int v = 0; v < 4; v++) begin
      mon = 32'(v) << 14; settle();
      chk("R6 spd field", en, (v == 2) ? 0 : 1);
    end
    mon = 32'h0000_8000; el64 = 4'b1101; cur_el = 0; sud = 1; settle();
    chk("R6 user override", en, 1);
    sud = 0; settle();
    chk("R6 el0 no override", en, 0);
    secure = 0; mon = '0; cur_el = 2; settle();
    chk("R7 ns el2", en, 0);
    cur_el = 1; settle();
    chk("R7 ns el1", en, 1);
    cur_el = 0; settle();
    chk("R7 ns el0", en, 1);
    secure = 1; el64 = 4'b1111; mon = 32'h0001_C000; settle();
    chk("R7 el0 under 64-bit el1", en, 0);
    defaults();
  endtask

  task automatic t_ss();
    ctl = 32'h0000_2001; settle();
    chk("R8 active", ss, 1);
    el64 = 4'b1101; settle();
    chk("R8 target 32-bit", ss, 0);
    el64 = 4'b1111; dmask = 1; settle();
    chk("R8 not enabled", ss, 0);
    dmask = 0; ctl = 32'h0000_2000; settle();
    chk("R8 bit0 clear", ss, 0);
    ctl = 32'h0000_2001;
    lock_wr(1, 0, 32'h1);
    chk("R10 dlock set", dlk, 1);
    chk("R3 dlock blocks", en, 0);
    chk("R8 dlock blocks ss", ss, 0);
    lock_wr(1, 0, 32'h0);
    chk("R10 dlock clear", dlk, 0);
    chk("R8 restored", ss, 1);
    defaults();
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_lock_writes();
    t_target();
    t_en64();
    t_en32();
    t_ss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule